// File: doc/BRIEF.md
# Parallel Printer Port Host Register Block

This block is the host-facing register set and pin logic of a PC-style parallel printer port. A simple byte-wide I/O bus selects one of four registers with a 2-bit offset and qualifies each access with a one-cycle write or read strobe. The four registers are data, status, control and peripheral address. Read data is registered and is valid on the cycle after the read strobe.

The control register drives the printer handshake outputs. Each output has its own fixed polarity. The status register returns the printer status inputs, and only the busy input is complemented. A rising edge on the acknowledge input, seen through a synchronizer, raises a level interrupt while the interrupt-enable bit is set.

A 2-bit mode input picks plain printer, bidirectional, EPP or ECP operation. The mode affects only one thing: whether the control direction bit may turn the 8-bit data lines around to input.

Top module: `pport_host_if`

## Requirements
- R1: During and after reset, and before any write: the control register is 0, so `strobe_n`, `autofd_n` and `selin_n` are 1 and `init_n` is 0. At the same time `irq` is 0, `pd_out` is 0x00, and a read of offset 3 returns 0x00.
- R2: A read of offset 1 returns the raw error input in bit 3, select in bit 4, paper-end in bit 5 and acknowledge in bit 6, and 0 in bits 2..0.
- R3: Bit 7 of an offset-1 read is the complement of `busy_in`.
- R4: Control bits 0, 1 and 3 appear inverted on `strobe_n`, `autofd_n` and `selin_n`. Control bit 2 appears unchanged on `init_n`.
- R5: Offset 2 holds the control register. Bits 5..0 are writable and read back. Bits 7..6 always read 0, whatever value is written.
- R6: With control bit 4 at 1, a low-to-high transition of `ack_n_in` sets `irq` within four clock cycles. `irq` then stays at 1 until the next read of offset 1.
- R7: With control bit 4 at 0, `irq` stays 0, even across acknowledge edges. Clearing bit 4 drops a pending `irq` within two cycles.
- R8: With `port_mode` = 00 (printer), `pd_oe` is 1 whatever control bit 5 holds. For modes 01, 10 and 11, `pd_oe` is the inverse of control bit 5.
- R9: A write to offset 0 puts the byte on `pd_out`. A read of offset 0 returns that byte while `pd_oe` is 1, and returns `pd_in` while `pd_oe` is 0.
- R10: A write to offset 3 stores the byte, which reads back at offset 3. The same write also places the byte on `pd_out` without inversion.
- R11: A write to offset 1 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| port_mode | input | 2 | 00 printer, 01 bidirectional, 10 EPP, 11 ECP |
| pd_out | output | 8 | Data lines, outbound value |
| pd_in | input | 8 | Data lines, sampled inbound value |
| pd_oe | output | 1 | 1 = data lines driven outward |
| strobe_n | output | 1 | Strobe output, active low |
| autofd_n | output | 1 | Auto line feed output, active low |
| init_n | output | 1 | Initialize output, active low |
| selin_n | output | 1 | Select-printer output, active low |
| err_n_in | input | 1 | Error status, 0 = error |
| slct_in | input | 1 | Printer on line |
| pe_in | input | 1 | Paper end |
| ack_n_in | input | 1 | Acknowledge, asynchronous |
| busy_in | input | 1 | Printer busy |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its default parameters: 8-bit data and a two-stage acknowledge synchronizer. At these values every control and status bit position can be observed at the ports. The acknowledge path has its minimum latency, so each interrupt edge settles within a few cycles of the bench's fixed waits. All four port modes are swept with the direction bit at both values. This checks that printer mode alone overrides the direction bit, and that data reads switch between the latched byte and the pin sample.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    MODE_SPP   = 2'b00,
    MODE_BIDIR = 2'b01,
    MODE_EPP   = 2'b10,
    MODE_ECP   = 2'b11
  } pmode_e;

  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;
  localparam logic [1:0] OFF_ADDR = 2'd3;

  localparam int CTL_W   = 6;
  localparam int CB_STB  = 0;
  localparam int CB_AFD  = 1;
  localparam int CB_INIT = 2;
  localparam int CB_SEL  = 3;
  localparam int CB_IEN  = 4;
  localparam int CB_DIR  = 5;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pport_ack_irq.sv
module pport_ack_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  input  logic ien,
  input  logic clr,
  output logic irq
);
  logic ack_s, ack_d, rise;

  pport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(ack_n), .q(ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ack_d <= 1'b1;
    else     ack_d <= ack_s;
  end

  assign rise = ack_s & ~ack_d;

  always_ff @(posedge clk) begin
    if (rst)       irq <= 1'b0;
    else if (!ien) irq <= 1'b0;
    else if (rise) irq <= 1'b1;
    else if (clr)  irq <= 1'b0;
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ien) && $past(rise)); // R6
  AST_IRQ_DROPS_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(ien) |=> !irq); // R7
endmodule

// File: rtl/pport_dir.sv
module pport_dir
  import pport_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       dir_in,
  output logic       oe
);
  always_comb begin
    case (pmode_e'(mode))
      MODE_SPP: oe = 1'b1;
      default:  oe = ~dir_in;
    endcase
  end
endmodule

// File: rtl/pport_host_if.sv
module pport_host_if
  import pport_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [1:0]    port_mode,
  output logic [DW-1:0] pd_out,
  input  logic [DW-1:0] pd_in,
  output logic          pd_oe,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          init_n,
  output logic          selin_n,
  input  logic          err_n_in,
  input  logic          slct_in,
  input  logic          pe_in,
  input  logic          ack_n_in,
  input  logic          busy_in,
  output logic          irq
);
  localparam int PAD_W = DW - CTL_W;

  logic [DW-1:0]    data_q, addr_q, rd_mux, stat_w;
  logic [CTL_W-1:0] ctl_q;
  logic             wr_data, wr_ctrl, wr_addr, rd_stat;

  assign wr_data = bus_wr && bus_addr == OFF_DATA;
  assign wr_ctrl = bus_wr && bus_addr == OFF_CTRL;
  assign wr_addr = bus_wr && bus_addr == OFF_ADDR;
  assign rd_stat = bus_rd && bus_addr == OFF_STAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      addr_q <= '0;
      pd_out <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_data) begin
        data_q <= bus_wdata;
        pd_out <= bus_wdata;
      end
      if (wr_addr) begin
        addr_q <= bus_wdata;
        pd_out <= bus_wdata;
      end
      if (wr_ctrl) ctl_q <= bus_wdata[CTL_W-1:0];
    end
  end

  assign strobe_n = ~ctl_q[CB_STB];
  assign autofd_n = ~ctl_q[CB_AFD];
  assign init_n   =  ctl_q[CB_INIT];
  assign selin_n  = ~ctl_q[CB_SEL];

  pport_dir u_dir (
    .mode(port_mode), .dir_in(ctl_q[CB_DIR]), .oe(pd_oe)
  );

  pport_ack_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst(rst), .ack_n(ack_n_in), .ien(ctl_q[CB_IEN]),
    .clr(rd_stat), .irq(irq)
  );

  always_comb begin
    stat_w    = '0;
    stat_w[3] = err_n_in;
    stat_w[4] = slct_in;
    stat_w[5] = pe_in;
    stat_w[6] = ack_n_in;
    stat_w[7] = ~busy_in;
  end

  always_comb begin
    case (bus_addr)
      OFF_DATA: rd_mux = pd_oe ? data_q : pd_in;
      OFF_STAT: rd_mux = stat_w;
      OFF_CTRL: rd_mux = {{PAD_W{1'b0}}, ctl_q};
      default:  rd_mux = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RESET_PIN_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !init_n && strobe_n && autofd_n && selin_n && !irq); // R1
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == OFF_STAT) |-> bus_rdata[2:0] == 3'b000); // R2
  AST_BUSY_INVERTED: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == OFF_STAT) |-> bus_rdata[7] == !$past(busy_in)); // R3
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == OFF_CTRL) |-> bus_rdata[DW-1:CTL_W] == '0); // R5
  AST_PRINTER_DRIVES: assert property (@(posedge clk) disable iff (rst)
    port_mode == MODE_SPP |-> pd_oe); // R8
endmodule

// File: tb/pport_host_if_test.sv
module pport_host_if_test;
  logic       clk = 1'b0, rst = 1'b1;
  logic [1:0] bus_addr = '0, port_mode = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, pd_out, pd_in = 8'h3C;
  logic       pd_oe, strobe_n, autofd_n, init_n, selin_n, irq;
  logic       err_n_in = 1'b1, slct_in = 1'b0, pe_in = 1'b0;
  logic       ack_n_in = 1'b1, busy_in = 1'b0;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pport_host_if uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_mode(port_mode),
    .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .strobe_n(strobe_n),
    .autofd_n(autofd_n), .init_n(init_n), .selin_n(selin_n), .err_n_in(err_n_in),
    .slct_in(slct_in), .pe_in(pe_in), .ack_n_in(ack_n_in), .busy_in(busy_in),
    .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result one step after the capturing edge
  always @(posedge clk) begin
    if (bus_rd && !rst) begin
      #1;
      if (exp_q.size() == 0) check("SCOREBOARD", bus_rdata, 8'hxx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pins(string tag, logic s, logic a, logic i, logic l);
    check({tag, " strobe_n"}, {7'd0, strobe_n}, {7'd0, s});
    check({tag, " autofd_n"}, {7'd0, autofd_n}, {7'd0, a});
    check({tag, " init_n"},   {7'd0, init_n},   {7'd0, i});
    check({tag, " selin_n"},  {7'd0, selin_n},  {7'd0, l});
  endtask

  initial begin
    fork
      begin
        idle(3);
        pins("R1", 1, 1, 0, 1);
        check("R1 irq", {7'd0, irq}, 8'h00);
        @(negedge clk); rst = 1'b0;
        pins("R1", 1, 1, 0, 1);
        check("R1 pd_out", pd_out, 8'h00);
        check("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
        rd(2'd3, 8'h00, "R1 addr reg");
        rd(2'd2, 8'h00, "R1 ctrl reg");
        // control polarity and read-back
        wr(2'd2, 8'hFF);
        pins("R4 all set", 0, 0, 1, 0);
        rd(2'd2, 8'h3F, "R5 high bits");
        check("R8 printer ignores dir", {7'd0, pd_oe}, 8'h01);
        wr(2'd2, 8'h05);
        pins("R4 mixed", 0, 1, 1, 1);
        // status mapping
        err_n_in = 1; slct_in = 0; pe_in = 1; ack_n_in = 0; busy_in = 1;
        rd(2'd1, 8'h28, "R2 R3 status A");
        err_n_in = 0; slct_in = 1; pe_in = 0; ack_n_in = 1; busy_in = 0;
        rd(2'd1, 8'hD0, "R2 R3 status B");
        idle(5);
        check("R7 irq off without enable", {7'd0, irq}, 8'h00);
        // interrupt set and clear by status read
        ack_n_in = 0; idle(5);
        wr(2'd2, 8'h10);
        ack_n_in = 1; idle(5);
        check("R6 irq set", {7'd0, irq}, 8'h01);
        idle(6);
        check("R6 irq held", {7'd0, irq}, 8'h01);
        rd(2'd1, 8'hD0, "R6 status read");
        check("R6 irq cleared by read", {7'd0, irq}, 8'h00);
        // interrupt dropped by disabling
        ack_n_in = 0; idle(5); ack_n_in = 1; idle(5);
        check("R6 irq set again", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h00); idle(1);
        check("R7 irq dropped", {7'd0, irq}, 8'h00);
        // data register and direction
        wr(2'd0, 8'hA5);
        check("R9 pd_out", pd_out, 8'hA5);
        rd(2'd0, 8'hA5, "R9 read latched");
        port_mode = 2'b01; idle(1);
        check("R8 bidir out", {7'd0, pd_oe}, 8'h01);
        wr(2'd2, 8'h20);
        check("R8 bidir in", {7'd0, pd_oe}, 8'h00);
        rd(2'd0, 8'h3C, "R9 read pins");
        port_mode = 2'b10; idle(1);
        check("R8 epp in", {7'd0, pd_oe}, 8'h00);
        port_mode = 2'b11; idle(1);
        check("R8 ecp in", {7'd0, pd_oe}, 8'h00);
        port_mode = 2'b00; idle(1);
        check("R8 printer forces out", {7'd0, pd_oe}, 8'h01);
        // address register
        wr(2'd3, 8'h5A);
        check("R10 pd_out", pd_out, 8'h5A);
        rd(2'd3, 8'h5A, "R10 read");
        rd(2'd0, 8'hA5, "R9 data kept");
        // writes to status offset
        wr(2'd1, 8'hFF);
        rd(2'd2, 8'h20, "R11 ctrl kept");
        rd(2'd0, 8'hA5, "R11 data kept");
        rd(2'd3, 8'h5A, "R11 addr kept");
        check("R11 pd_out kept", pd_out, 8'h5A);
        check("R11 irq kept", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'hC0);
        rd(2'd2, 8'h00, "R5 top bits ignore write");
        idle(3);
        if (exp_q.size() != 0) check("SCOREBOARD drain", 8'(exp_q.size()), 8'h00);
      end
      begin
        idle(5000);
        check("WATCHDOG", 8'h01, 8'h00);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule